// File: doc/BRIEF.md
# Timer Control Page

This block is the control page that sits beside a pair of architected timers. It holds the shared counter frequency, a fixed identification word that advertises one timer frame with a virtual timer, two placeholder access-control words, and a 64-bit virtual offset. The offset is driven out continuously so that the timer frame can subtract it from the system count. Security and access-control words read as zero and ignore writes. Any unknown address inside the 4 KiB window reads as zero and ignores writes.

Software reaches the page through a simple request channel: one beat per access, with a byte count of 4 or 8. Every accepted request produces exactly one response beat one cycle later. `req_ready` is held high, so a request is taken in every cycle that `req_valid` is high. The response channel has no back-pressure, and the consumer must take `rsp_valid` whenever it appears. An access whose byte count is neither 4 nor 8 still gets its response beat, but with zero data and a one-cycle `size_err` pulse. Such an access changes no state.

Top module: `tmr_ctrl_page`

## Requirements
- R1: `req_ready` is always 1. A request with `req_valid` high at a rising edge gives `rsp_valid` high for exactly the following cycle. With no request, `rsp_valid` stays low.
- R2: A request whose `req_size` is not 4 and not 8 raises `size_err` for one cycle together with `rsp_valid`. Its `rsp_rdata` is zero and it leaves `voffset_o` unchanged.
- R3: A 4-byte read at 0x000 returns the `CNT_FREQ` parameter in `rsp_rdata[31:0]`. A write there is ignored.
- R4: A 4-byte read at 0x008 returns 0x3 (bit 0 = frame 0 present, bit 1 = frame 0 has a virtual timer).
- R5: 4-byte reads at 0x004 and 0x040 return zero, and writes there are ignored.
- R6: A 4-byte write at 0x080 replaces offset bits 31:0 and keeps bits 63:32. A 4-byte write at 0x084 replaces bits 63:32 and keeps bits 31:0. In both cases the data is taken from `req_wdata[31:0]`.
- R7: A 4-byte read at 0x080 returns offset bits 31:0, and one at 0x084 returns offset bits 63:32.
- R8: An 8-byte access at 0x080 reads or writes the whole 64-bit offset.
- R9: An 8-byte access at any address other than 0x080 reads zero and ignores writes.
- R10: A 4-byte access at an address not listed in R3 to R7 reads zero and ignores writes.
- R11: The offset is zero after reset. `voffset_o` shows a written value from the cycle after the write is accepted.
- R12: Every 4-byte read response has `rsp_rdata[63:32]` equal to zero. Every write response has `rsp_rdata` equal to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request beat present |
| req_ready | output | 1 | Always 1; request taken whenever valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset inside the page |
| req_size | input | 4 | Access width in bytes (4 or 8 legal) |
| req_wdata | input | 64 | Write data; 4-byte writes use bits 31:0 |
| rsp_valid | output | 1 | Response beat, one cycle after the request |
| rsp_rdata | output | 64 | Read data, zero for writes and errors |
| size_err | output | 1 | One-cycle pulse with the response of an illegal-size access |
| voffset_o | output | 64 | Current virtual offset to the timer frame |

## Verification
The bench builds the page with `CNT_FREQ` set to 0x01234567 instead of the default. A frequency read can therefore be told apart from a stale value, from the identification word and from zero. The data and address widths stay at 64 and 12, so every decoded offset and both halves of the offset register can be reached. Random 4-byte, 8-byte and illegal-size accesses are aimed mostly at the decoded offsets and their neighbours. These accesses exercise interleaved half-writes and whole-offset writes, and ignored writes to every read-only or undecoded word.

// File: rtl/tcf_pkg.sv
package tcf_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_FREQ,
    SEL_NSACC,
    SEL_IDENT,
    SEL_ACCTL,
    SEL_VOFF_LO,
    SEL_VOFF_HI,
    SEL_VOFF_W
  } tcf_sel_e;

  localparam int unsigned OFS_FREQ    = 'h000;
  localparam int unsigned OFS_NSACC   = 'h004;
  localparam int unsigned OFS_IDENT   = 'h008;
  localparam int unsigned OFS_ACCTL   = 'h040;
  localparam int unsigned OFS_VOFF_LO = 'h080;
  localparam int unsigned OFS_VOFF_HI = 'h084;

  // frame 0 present, frame 0 carries a virtual timer
  localparam logic [31:0] TCF_IDENT = 32'h0000_0003;

endpackage

// File: rtl/tcf_decode.sv
module tcf_decode
  import tcf_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SZ_W   = 4,
  parameter int DATA_W = 64
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SZ_W-1:0]   size,
  output tcf_sel_e          sel,
  output logic              size_ok
);
  localparam int NARROW_B = DATA_W / 16;
  localparam int WIDE_B   = DATA_W / 8;

  logic is_narrow, is_wide;

  always_comb begin
    is_narrow = (size == SZ_W'(NARROW_B));
    is_wide   = (size == SZ_W'(WIDE_B));
    size_ok   = is_narrow | is_wide;
    sel       = SEL_NONE;
    if (is_narrow) begin
      if      (addr == ADDR_W'(OFS_FREQ))    sel = SEL_FREQ;
      else if (addr == ADDR_W'(OFS_NSACC))   sel = SEL_NSACC;
      else if (addr == ADDR_W'(OFS_IDENT))   sel = SEL_IDENT;
      else if (addr == ADDR_W'(OFS_ACCTL))   sel = SEL_ACCTL;
      else if (addr == ADDR_W'(OFS_VOFF_LO)) sel = SEL_VOFF_LO;
      else if (addr == ADDR_W'(OFS_VOFF_HI)) sel = SEL_VOFF_HI;
    end else if (is_wide) begin
      if (addr == ADDR_W'(OFS_VOFF_LO)) sel = SEL_VOFF_W;
    end
  end
endmodule

// File: rtl/tcf_voff.sv
module tcf_voff
  import tcf_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  tcf_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] off_q
);
  localparam int HALF  = DATA_W / 2;
  localparam int LANES = 2;

  logic [LANES-1:0] lane_we;

  always_comb begin
    lane_we[0] = we & ((sel == SEL_VOFF_LO) | (sel == SEL_VOFF_W));
    lane_we[1] = we & ((sel == SEL_VOFF_HI) | (sel == SEL_VOFF_W));
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [HALF-1:0] src;
    // whole-offset writes place each half in its own lane; half writes use the low word
    assign src = (sel == SEL_VOFF_W) ? wdata[k*HALF +: HALF] : wdata[HALF-1:0];
    always_ff @(posedge clk) begin
      if (!rst_n)          off_q[k*HALF +: HALF] <= '0;
      else if (lane_we[k]) off_q[k*HALF +: HALF] <= src;
    end
  end

  // R11
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(off_q));
  // R6
  hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == SEL_VOFF_HI) |=> off_q[HALF-1:0] == $past(off_q[HALF-1:0]));
  // R6
  lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == SEL_VOFF_LO) |=> off_q[DATA_W-1:HALF] == $past(off_q[DATA_W-1:HALF]));
endmodule

// File: rtl/tcf_rsp.sv
module tcf_rsp
  import tcf_pkg::*;
#(
  parameter int          DATA_W   = 64,
  parameter logic [31:0] CNT_FREQ = 32'd50_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_fire,
  input  logic              is_write,
  input  logic              size_ok,
  input  tcf_sel_e          sel,
  input  logic [DATA_W-1:0] off,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              size_err
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    if (size_ok && !is_write) begin
      case (sel)
        SEL_FREQ:    rd_d[HALF-1:0] = HALF'(CNT_FREQ);
        SEL_IDENT:   rd_d[HALF-1:0] = HALF'(TCF_IDENT);
        SEL_VOFF_LO: rd_d[HALF-1:0] = off[HALF-1:0];
        SEL_VOFF_HI: rd_d[HALF-1:0] = off[DATA_W-1:HALF];
        SEL_VOFF_W:  rd_d           = off;
        default:     rd_d           = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      size_err  <= 1'b0;
    end else begin
      rsp_valid <= req_fire;
      rsp_rdata <= req_fire ? rd_d : '0;
      size_err  <= req_fire & ~size_ok;
    end
  end

  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> rsp_valid);
  // R1
  rsp_only_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_fire |=> !rsp_valid);
  // R2
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> (rsp_valid && rsp_rdata == '0));
  // R4
  ident_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && !is_write && sel == SEL_IDENT) |=> rsp_rdata == DATA_W'(TCF_IDENT));
endmodule

// File: rtl/tmr_ctrl_page.sv
module tmr_ctrl_page
  import tcf_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter int          SZ_W     = 4,
  parameter int          DATA_W   = 64,
  parameter logic [31:0] CNT_FREQ = 32'd50_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SZ_W-1:0]   req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              size_err,
  output logic [DATA_W-1:0] voffset_o
);
  tcf_sel_e sel;
  logic     size_ok;
  logic     fire;

  assign req_ready = 1'b1;
  assign fire      = req_valid;

  tcf_decode #(.ADDR_W(ADDR_W), .SZ_W(SZ_W), .DATA_W(DATA_W)) u_dec (
    .addr    (req_addr),
    .size    (req_size),
    .sel     (sel),
    .size_ok (size_ok)
  );

  tcf_voff #(.DATA_W(DATA_W)) u_voff (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (fire & req_write),
    .sel   (sel),
    .wdata (req_wdata),
    .off_q (voffset_o)
  );

  tcf_rsp #(.DATA_W(DATA_W), .CNT_FREQ(CNT_FREQ)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_fire  (fire),
    .is_write  (req_write),
    .size_ok   (size_ok),
    .sel       (sel),
    .off       (voffset_o),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .size_err  (size_err)
  );

  // R2
  err_keeps_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> $stable(voffset_o));
  // R12
  write_rsp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> rsp_rdata == '0);
endmodule

// File: tb/tb_tmr_ctrl_page.sv
module tb_tmr_ctrl_page;
  localparam logic [31:0] FREQ = 32'h0123_4567;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [3:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic        req_ready, rsp_valid, size_err;
  logic [63:0] rsp_rdata, voffset_o;

  int total = 0, bad = 0;
  logic [63:0] m_off = '0;
  bit done = 0;

  always #10 clk = ~clk;

  tmr_ctrl_page #(.CNT_FREQ(FREQ)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .size_err(size_err), .voffset_o(voffset_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_rd(input logic [11:0] a, input logic [3:0] s,
                                         input logic [63:0] off);
    if (s == 4) begin
      case (a)
        12'h000: return {32'h0, FREQ};
        12'h008: return 64'h3;
        12'h080: return {32'h0, off[31:0]};
        12'h084: return {32'h0, off[63:32]};
        default: return 64'h0;
      endcase
    end else if (s == 8 && a == 12'h080) return off;
    return 64'h0;
  endfunction

  function automatic string tag_of(input logic [11:0] a, input logic [3:0] s);
    if (s != 4 && s != 8) return "R2";
    if (s == 8) return (a == 12'h080) ? "R8" : "R9";
    case (a)
      12'h000: return "R3";
      12'h008: return "R4";
      12'h004, 12'h040: return "R5";
      12'h080, 12'h084: return "R7";
      default: return "R10";
    endcase
  endfunction

  // called at a negedge; returns at the next negedge after checking
  task automatic op(input bit w, input logic [11:0] a, input logic [3:0] s,
                    input logic [63:0] d);
    logic [63:0] er;
    bit          ee;
    string       t;
    er = w ? 64'h0 : exp_rd(a, s, m_off);
    ee = (s != 4 && s != 8);
    t  = tag_of(a, s);
    if (w && !ee) begin
      if (s == 4 && a == 12'h080) begin m_off[31:0]  = d[31:0]; t = "R6"; end
      if (s == 4 && a == 12'h084) begin m_off[63:32] = d[31:0]; t = "R6"; end
      if (s == 8 && a == 12'h080) m_off = d;
    end
    req_valid = 1'b1; req_write = w; req_addr = a; req_size = s; req_wdata = d;
    chk(req_ready === 1'b1, "R1 ready", {63'h0, req_ready}, 64'h1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1, "R1 rsp_valid", {63'h0, rsp_valid}, 64'h1);
    chk(rsp_rdata === er, w ? "R12 write data" : t, rsp_rdata, er);
    chk(size_err === ee, "R2 size_err", {63'h0, size_err}, {63'h0, ee});
    chk(voffset_o === m_off, w ? (ee ? "R2 offset" : t) : "R11 offset", voffset_o, m_off);
  endtask

  task automatic idle();
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R1 idle", {63'h0, rsp_valid}, 64'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1337));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk(voffset_o === 64'h0, "R11 reset offset", voffset_o, 64'h0);
    chk(rsp_valid === 1'b0, "R1 reset rsp", {63'h0, rsp_valid}, 64'h0);
    chk(size_err === 1'b0, "R2 reset err", {63'h0, size_err}, 64'h0);
    // directed corners
    op(0, 12'h000, 4, 0);                       // R3
    op(1, 12'h000, 4, 64'hFFFF_FFFF);           // R3 write ignored
    op(0, 12'h000, 4, 0);
    op(0, 12'h008, 4, 0);                       // R4
    op(1, 12'h004, 4, 64'h5A5A); op(0, 12'h004, 4, 0);   // R5
    op(1, 12'h040, 4, 64'h1234); op(0, 12'h040, 4, 0);   // R5
    op(1, 12'h080, 4, 64'hDEAD_BEEF_1111_2222); // R6 low from wdata[31:0]
    op(1, 12'h084, 4, 64'h0BAD_F00D_3333_4444); // R6 high
    op(0, 12'h080, 4, 0); op(0, 12'h084, 4, 0); // R7
    op(1, 12'h080, 8, 64'hCAFE_0001_BEEF_0002); // R8 write
    op(0, 12'h080, 8, 0);                       // R8 read
    op(1, 12'h084, 8, 64'hFFFF_FFFF_FFFF_FFFF); // R9 ignored
    op(0, 12'h000, 8, 0);                       // R9 reads zero
    op(1, 12'h088, 4, 64'h77); op(0, 12'h088, 4, 0);     // R10
    op(1, 12'h080, 2, 64'h1); op(0, 12'h080, 0, 0);      // R2
    op(1, 12'h080, 12, 64'h1);                  // R2
    idle();
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [11:0] a;
      logic [3:0]  s;
      int          r;
      r = $urandom % 10;
      case (r)
        0: a = 12'h000; 1: a = 12'h004; 2: a = 12'h008; 3: a = 12'h040;
        4, 5: a = 12'h080; 6: a = 12'h084; 7: a = 12'h07C;
        default: a = 12'($urandom);
      endcase
      r = $urandom % 8;
      if (r < 4) s = 4;
      else if (r < 7) s = 8;
      else begin
        s = 4'($urandom);
        if (s == 4 || s == 8) s = 4'd3;
      end
      op($urandom % 2 == 1, a, s, {$urandom, $urandom});
      if ($urandom % 6 == 0) idle();
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule